// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Logic

This block turns three Hall-sensor logic levels into the six switch enables of a three-phase bridge: one high-side and one low-side enable per phase. Each valid rotor position selects one phase to source current and one phase to sink it. A direction input selects reverse rotation. In reverse, the Hall code is bit-inverted before it is looked up in the same six-step table.

The high-side switch of the sourcing phase stays on for the whole step. Chopping is done only on the low side. The low side is gated by an externally generated PWM level, a current-limit flag and a lock-protection flag. A current-limit event switches the low side off for the rest of the running PWM period, so the limiter only ever shortens on-time.

A start/stop input disables the bridge. When the synchronised direction changes, every switch is held off for a programmable dead interval so that a reversal at speed cannot short a leg. The Hall and direction inputs are asynchronous and pass through a two-stage synchroniser. The control pins are plain levels: there is no stream interface and no back-pressure.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_raw` low, code {hall_raw[2],hall_raw[1],hall_raw[0]} selects (source phase, sink phase) as follows: 101→(P2,P1), 100→(P3,P1), 110→(P3,P2), 010→(P1,P2), 011→(P1,P3), 001→(P2,P3). Phase P1 is bit 0, P2 is bit 1 and P3 is bit 2 of `hi_en` and `lo_en`.
- R2: With `dir_raw` high, the Hall code is bit-inverted before the R1 lookup. For example, 010 drives source P2 and sink P1.
- R3: Hall codes 000 and 111 switch all six enables off.
- R4: While `pwm_on` is low, every low-side enable is off and the selected high-side enable stays on.
- R5: Once `ilim` is seen high, the low side stays off until the next rising edge of `pwm_on`, even if `ilim` has already dropped. The high side is unaffected.
- R6: While `prot_off` is high, all low-side enables are off. The high side is unaffected.
- R7: While `run_n` is high (stop, which is also the level of an unconnected pulled-up pin), all six enables are off.
- R8: After the synchronised direction changes, all six enables are off for DEAD_CYC consecutive cycles. The new direction's table then applies.
- R9: A phase never has its high-side and low-side enables on in the same cycle. At most one high-side and at most one low-side enable is on.
- R10: During reset all six enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_raw | input | 3 | Asynchronous Hall levels, bit 2 = sensor 1 |
| dir_raw | input | 1 | Asynchronous direction, high = reverse |
| run_n | input | 1 | High = stop, low = run |
| pwm_on | input | 1 | PWM on-phase level for the low side |
| ilim | input | 1 | Current-limit flag, ends the current on-time |
| prot_off | input | 1 | Lock-protection flag, forces the low side off |
| hi_en | output | 3 | High-side enables, bit n = phase n+1 |
| lo_en | output | 3 | Low-side enables, bit n = phase n+1 |

## Verification
The hardest case to reach is a direction reversal while the motor is running. The block must pass from one valid step to the opposite-direction step without ever driving a leg from both ends. The stimulus holds a legal Hall code with PWM active, flips `dir_raw`, and samples inside the dead window and again after it, in both directions. Next hardest is the current-limit hold: `ilim` is pulsed and released within one PWM on-phase, and the bench shows that the low side stays off until the next PWM rising edge.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int PHASES = 3;
  typedef logic [PHASES-1:0] phase_vec_t;

  typedef struct packed {
    logic       legal;
    phase_vec_t src;
    phase_vec_t snk;
  } step_t;

  // Six-step forward table; code order {s1,s2,s3}, phase P1 = bit 0
  function automatic step_t step_lookup(input logic [2:0] code);
    step_t s;
    s = '{legal: 1'b1, src: '0, snk: '0};
    unique case (code)
      3'b101: begin s.src = 3'b010; s.snk = 3'b001; end
      3'b100: begin s.src = 3'b100; s.snk = 3'b001; end
      3'b110: begin s.src = 3'b100; s.snk = 3'b010; end
      3'b010: begin s.src = 3'b001; s.snk = 3'b010; end
      3'b011: begin s.src = 3'b001; s.snk = 3'b100; end
      3'b001: begin s.src = 3'b010; s.snk = 3'b100; end
      default: s.legal = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cmu_sync.sv
module cmu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[g] <= '0;
          else        st[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[g] <= '0;
          else        st[g] <= st[g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/cmu_step_decode.sv
module cmu_step_decode
  import cmu_pkg::*;
(
  input  logic [2:0] code,
  input  logic       reverse,
  output phase_vec_t src,
  output phase_vec_t snk,
  output logic       legal
);
  logic [2:0] eff_code;
  step_t      step;

  // Reverse rotation reuses the forward table on the complemented code
  assign eff_code = reverse ? ~code : code;
  assign step     = step_lookup(eff_code);
  assign src      = step.src;
  assign snk      = step.snk;
  assign legal    = step.legal;
endmodule

// File: rtl/cmu_dead_guard.sv
module cmu_dead_guard #(
  parameter int DEAD_CYC = 8,
  localparam int CW      = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_s,
  output logic dead
);
  logic          dir_q;
  logic [CW-1:0] cnt;
  logic          flip;

  assign flip = dir_s ^ dir_q;
  assign dead = flip | (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      cnt   <= '0;
    end else begin
      dir_q <= dir_s;
      if (flip)            cnt <= CW'(DEAD_CYC - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cmu_drive.sv
module cmu_drive
  import cmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_vec_t src,
  input  phase_vec_t snk,
  input  logic       legal,
  input  logic       run_n,
  input  logic       dead,
  input  logic       pwm_on,
  input  logic       ilim,
  input  logic       prot_off,
  output phase_vec_t hi_en,
  output phase_vec_t lo_en
);
  logic       pwm_q;
  logic       lim_hold;
  logic       pwm_rise;
  logic       step_ok;
  logic       lo_allow;
  phase_vec_t hi_d;
  phase_vec_t lo_d;

  assign pwm_rise = pwm_on & ~pwm_q;
  assign step_ok  = legal & ~run_n & ~dead;
  assign lo_allow = pwm_on & ~ilim & ~prot_off & (~lim_hold | pwm_rise);

  // The limiter hold lasts until the next PWM period begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      lim_hold <= 1'b0;
    end else begin
      pwm_q <= pwm_on;
      if (ilim)          lim_hold <= 1'b1;
      else if (pwm_rise) lim_hold <= 1'b0;
    end
  end

  generate
    for (genvar p = 0; p < PHASES; p++) begin : g_leg
      assign hi_d[p] = step_ok & src[p];
      assign lo_d[p] = step_ok & snk[p] & lo_allow;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_en[p] <= 1'b0;
          lo_en[p] <= 1'b0;
        end else begin
          hi_en[p] <= hi_d[p];
          lo_en[p] <= lo_d[p];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import cmu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYC    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_raw,
  input  logic       dir_raw,
  input  logic       run_n,
  input  logic       pwm_on,
  input  logic       ilim,
  input  logic       prot_off,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en
);
  logic [3:0] sync_q;
  logic [2:0] hall_s;
  logic       dir_s;
  phase_vec_t src;
  phase_vec_t snk;
  logic       legal;
  logic       dead;

  cmu_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dir_raw, hall_raw}), .q(sync_q)
  );

  assign hall_s = sync_q[2:0];
  assign dir_s  = sync_q[3];

  cmu_step_decode u_decode (
    .code(hall_s), .reverse(dir_s), .src(src), .snk(snk), .legal(legal)
  );

  cmu_dead_guard #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_n), .dir_s(dir_s), .dead(dead)
  );

  cmu_drive u_drive (
    .clk(clk), .rst_n(rst_n), .src(src), .snk(snk), .legal(legal),
    .run_n(run_n), .dead(dead), .pwm_on(pwm_on), .ilim(ilim),
    .prot_off(prot_off), .hi_en(hi_en), .lo_en(lo_en)
  );
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall_s,
  input logic       dir_s,
  input logic       dead,
  input logic       run_n,
  input logic       pwm_on,
  input logic       ilim,
  input logic       prot_off,
  input logic [2:0] hi_en,
  input logic [2:0] lo_en
);
  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en & lo_en) == 3'b000);

  assert_single_leg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_en) && $onehot0(lo_en));

  assert_illegal_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_s == 3'b000 || hall_s == 3'b111) |=> (hi_en == 3'b000 && lo_en == 3'b000));

  assert_stop_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> (hi_en == 3'b000 && lo_en == 3'b000));

  assert_pwm_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> lo_en == 3'b000);

  assert_ilim_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |=> lo_en == 3'b000);

  assert_prot_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prot_off |=> lo_en == 3'b000);

  assert_dir_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_s != $past(dir_s)) |=> (hi_en == 3'b000 && lo_en == 3'b000));

  assert_dead_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> (hi_en == 3'b000 && lo_en == 3'b000));
endmodule

bind hall_commutator hall_commutator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hall_s(hall_s), .dir_s(dir_s), .dead(dead),
  .run_n(run_n), .pwm_on(pwm_on), .ilim(ilim), .prot_off(prot_off),
  .hi_en(hi_en), .lo_en(lo_en)
);

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_raw = 3'b000;
  logic       dir_raw = 1'b0;
  logic       run_n = 1'b1;
  logic       pwm_on = 1'b1;
  logic       ilim = 1'b0;
  logic       prot_off = 1'b0;
  logic [2:0] hi_en, lo_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] q_hi [$];
  logic [2:0] q_lo [$];
  string      q_tag [$];

  always #4 clk = ~clk;

  hall_commutator u_dut (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .dir_raw(dir_raw),
    .run_n(run_n), .pwm_on(pwm_on), .ilim(ilim), .prot_off(prot_off),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  // Independent model of the forward six-step table (R1)
  function automatic logic [5:0] ref_step(input logic [2:0] c);
    case (c)
      3'b101: return {3'b010, 3'b001};
      3'b100: return {3'b100, 3'b001};
      3'b110: return {3'b100, 3'b010};
      3'b010: return {3'b001, 3'b010};
      3'b011: return {3'b001, 3'b100};
      3'b001: return {3'b010, 3'b100};
      default: return 6'b0;
    endcase
  endfunction

  task automatic push_exp(input logic [2:0] h, input logic [2:0] l, input string tag);
    q_hi.push_back(h);
    q_lo.push_back(l);
    q_tag.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares design outputs against the scoreboard queue
  always @(negedge clk) begin
    if (q_hi.size() > 0) begin
      logic [2:0] eh, el;
      string t;
      eh = q_hi.pop_front();
      el = q_lo.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (hi_en !== eh || lo_en !== el) begin
        fails++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", t, hi_en, lo_en, eh, el);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] r;
    settle(3);
    push_exp(3'b000, 3'b000, "R10 outputs off in reset");
    rst_n = 1'b1;
    hall_raw = 3'b101;
    settle(6);
    push_exp(3'b000, 3'b000, "R7 stop holds bridge off");
    run_n = 1'b0;

    // R1: forward table
    for (int i = 0; i < 6; i++) begin
      logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
      hall_raw = codes[i];
      settle(6);
      r = ref_step(codes[i]);
      push_exp(r[5:3], r[2:0], "R1 forward step");
    end

    // R3: illegal codes
    hall_raw = 3'b000; settle(6); push_exp(3'b000, 3'b000, "R3 code 000");
    hall_raw = 3'b111; settle(6); push_exp(3'b000, 3'b000, "R3 code 111");

    // R8: reversal while running, forward to reverse
    hall_raw = 3'b101; settle(6);
    push_exp(3'b010, 3'b001, "R8 before reversal");
    dir_raw = 1'b1;
    settle(3);
    push_exp(3'b000, 3'b000, "R8 dead window fwd->rev");
    settle(12);
    push_exp(3'b001, 3'b010, "R8 reverse step after dead window");

    // R2: reverse table on every legal code
    for (int i = 0; i < 6; i++) begin
      logic [2:0] codes [6] = '{3'b010, 3'b011, 3'b001, 3'b101, 3'b100, 3'b110};
      hall_raw = codes[i];
      settle(6);
      r = ref_step(~codes[i]);
      push_exp(r[5:3], r[2:0], "R2 reverse step");
    end

    // R8: reversal back to forward
    hall_raw = 3'b110; settle(6);
    dir_raw = 1'b0;
    settle(3);
    push_exp(3'b000, 3'b000, "R8 dead window rev->fwd");
    settle(12);
    push_exp(3'b100, 3'b010, "R8 forward step after dead window");

    // R4: PWM chops low side only
    pwm_on = 1'b0; settle(4);
    push_exp(3'b100, 3'b000, "R4 pwm off keeps high side");
    pwm_on = 1'b1; settle(4);
    push_exp(3'b100, 3'b010, "R4 pwm on restores low side");

    // R5: current-limit pulse holds until next PWM period
    ilim = 1'b1; settle(2);
    push_exp(3'b100, 3'b000, "R5 limit active");
    ilim = 1'b0; settle(3);
    push_exp(3'b100, 3'b000, "R5 limit held within period");
    pwm_on = 1'b0; settle(3);
    pwm_on = 1'b1; settle(3);
    push_exp(3'b100, 3'b010, "R5 next period restores low side");

    // R6: protection forces low side off
    prot_off = 1'b1; settle(3);
    push_exp(3'b100, 3'b000, "R6 protection low side off");
    prot_off = 1'b0; settle(3);
    push_exp(3'b100, 3'b010, "R6 protection released");

    // R7: stop while running
    run_n = 1'b1; settle(3);
    push_exp(3'b000, 3'b000, "R7 stop while running");
    run_n = 1'b0; settle(3);
    push_exp(3'b100, 3'b010, "R9 restart legal step, legs disjoint");

    settle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule